// File: doc/BRIEF.md
# Watchdog Countdown Timer with Coded Prescaler

This block is a watchdog that software services over a small register bus. A 16-bit counter counts down from a value that software writes. A prescaler sets the rate at which the counter steps. A 4-bit code selects the division: code 0 steps on every clock, and code k from 1 to 15 divides by 2^(k+1), so code 15 divides by 65536.

A control word holds three fields: an enable bit, a 2-bit mode and the prescale code. Every write to the load register restarts the countdown from the written value, and this write is the service operation. In watchdog mode (mode 3), the counter stepping from 1 to 0 raises a reset request. The request stays high until the block's own reset is applied. A load value of zero never expires. Loading 1 with prescale code 0 forces an expiry on the next step.

Top module: `wdog_timer`

## Requirements
- R1: After reset, reads at offset 0x0 and offset 0x8 both return zero, and `rst_req` is low.
- R2: A write at offset 0x0 stores bits 15:0 of the write data as the load value, and a later read at 0x0 returns it with bits 31:16 zero. The same write restarts the countdown from that value.
- R3: A write at offset 0x8 stores the enable in bit 7, the mode in bits 5:4 and the prescale code in bits 3:0. A read at 0x8 returns these fields with all other bits zero. A read at any other offset returns zero.
- R4: While the timer is enabled, the counter steps once per clock for prescale code 0, and once every 2^(code+1) clocks for codes 1 to 15. Every control write restarts the prescale period, so the first step comes one full period after that write.
- R5: In mode 3 with the timer enabled, a step that takes the counter from 1 to 0 sets `rst_req` at that clock edge.
- R6: Once set, `rst_req` stays high until `rst_n` is asserted, whatever is written to the registers.
- R7: A counter holding 0 does not step and never sets `rst_req`.
- R8: While the enable bit is clear, the counter holds its value and `rst_req` does not rise. Setting the enable bit again resumes counting from the held value.
- R9: In modes 0, 1 and 2 the counter still counts down, but reaching 0 does not set `rst_req`.
- R10: If a load write and a step fall in the same cycle, the load wins. The counter takes the written value and no expiry occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | Sticky watchdog reset request |

## Verification
Assertions are checked on every cycle for the following:
- the stickiness of `rst_req`;
- a counter at zero staying at zero;
- the counter holding while disabled;
- non-watchdog modes never raising the request;
- load-over-step priority;
- the step on every clock at code 0;
- the expiry that follows a 1-to-0 step.

Some behaviour can only be shown by the bench's scenarios. These are the exact expiry cycle for long prescale codes, the divider restart on a control rewrite, the fact that counting really continues in the other modes, and resumption after re-enable. The bench's behavioural model checks that expiry timing against the ports on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W  = 16;
  localparam int DIV_W  = 16;
  localparam int PS_W   = 4;
  localparam int MODE_W = 2;
  localparam logic [MODE_W-1:0] MODE_WATCHDOG = 2'd3;

  typedef struct packed {
    logic              en;
    logic [MODE_W-1:0] mode;
    logic [PS_W-1:0]   ps;
  } ctrl_t;

  // Last divider phase for a prescale code: period 1 for code 0,
  // 2^(code+1) otherwise.
  function automatic logic [DIV_W-1:0] ps_last(input logic [PS_W-1:0] code);
    int period;
    period = (code == '0) ? 1 : (1 << (int'(code) + 1));
    return DIV_W'(period - 1);
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int LOAD_OFFS = 0,
  parameter int CTRL_OFFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              load_wr_o,
  output logic              ctrl_wr_o,
  output logic [CNT_W-1:0]  load_o,
  output ctrl_t             ctrl_o
);
  localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'(LOAD_OFFS);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFFS);
  localparam int EN_BIT   = 7;
  localparam int MODE_LSB = 4;

  logic [CNT_W-1:0] load_q;
  ctrl_t            ctrl_q;
  logic             unused_wbits;

  assign load_wr_o = we_i && (addr_i == A_LOAD);
  assign ctrl_wr_o = we_i && (addr_i == A_CTRL);
  assign unused_wbits = ^{wdata_i[DATA_W-1:CNT_W], wdata_i[CNT_W-1:EN_BIT+1], wdata_i[6]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (load_wr_o) load_q <= wdata_i[CNT_W-1:0];
      if (ctrl_wr_o) begin
        ctrl_q.en   <= wdata_i[EN_BIT];
        ctrl_q.mode <= wdata_i[MODE_LSB +: MODE_W];
        ctrl_q.ps   <= wdata_i[PS_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_LOAD) begin
      rdata_o[CNT_W-1:0] = load_q;
    end else if (addr_i == A_CTRL) begin
      rdata_o[EN_BIT]               = ctrl_q.en;
      rdata_o[MODE_LSB +: MODE_W]   = ctrl_q.mode;
      rdata_o[PS_W-1:0]             = ctrl_q.ps;
    end
  end

  assign load_o = load_q;
  assign ctrl_o = ctrl_q;

  assert_load_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr_o |=> (load_q == $past(wdata_i[CNT_W-1:0])));
  assert_ctrl_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_o |=> (ctrl_q.en == $past(wdata_i[EN_BIT])));
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale
  import wdog_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            clr_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            tick_o
);
  logic [DIV_W-1:0] div_q;

  assign tick_o = en_i && (div_q == ps_last(ps_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        div_q <= '0;
    else if (clr_i || !en_i || tick_o) div_q <= '0;
    else                               div_q <= div_q + 1'b1;
  end

  assert_fast_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && ps_i == '0) |-> tick_o);
  assert_no_tick_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !tick_o);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_wr_i,
  input  logic [CNT_W-1:0]  load_val_i,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;
  logic             expire;
  logic             req_q;

  assign step   = tick_i && !load_wr_i && (cnt_q != '0);
  assign expire = step && (cnt_q == CNT_W'(1)) && (mode_i == MODE_WATCHDOG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (load_wr_i) cnt_q <= load_val_i;
    else if (step)      cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (expire) req_q <= 1'b1;
  end

  assign rst_req_o = req_q;

  assert_expire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_wr_i && cnt_q == CNT_W'(1) && mode_i == MODE_WATCHDOG) |=> rst_req_o);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> rst_req_o);
  assert_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !load_wr_i) |=> (cnt_q == '0));
  assert_hold_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_wr_i) |=> $stable(cnt_q));
  assert_quiet_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_WATCHDOG && !rst_req_o) |=> !rst_req_o);
  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int LOAD_OFFS = 0,
  parameter int CTRL_OFFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  logic             load_wr;
  logic             ctrl_wr;
  logic [CNT_W-1:0] load_val;
  ctrl_t            ctrl;
  logic             tick;

  wdog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOAD_OFFS(LOAD_OFFS), .CTRL_OFFS(CTRL_OFFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .we_i(bus_we),
    .wdata_i(bus_wdata), .rdata_o(bus_rdata), .load_wr_o(load_wr),
    .ctrl_wr_o(ctrl_wr), .load_o(load_val), .ctrl_o(ctrl)
  );

  wdog_prescale u_ps (
    .clk(clk), .rst_n(rst_n), .en_i(ctrl.en), .clr_i(ctrl_wr),
    .ps_i(ctrl.ps), .tick_o(tick)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .load_wr_i(load_wr),
    .load_val_i(bus_wdata[CNT_W-1:0]), .tick_i(tick), .en_i(ctrl.en),
    .mode_i(ctrl.mode), .rst_req_o(rst_req)
  );

  logic unused_load;
  assign unused_load = ^load_val;

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!rst_n) && !$past(bus_we)) |-> !rst_req);
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  wdog_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  // Behavioural reference model
  int m_load, m_en, m_mode, m_ps, m_phase, m_cnt, m_req;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_load = 0; m_en = 0; m_mode = 0; m_ps = 0; m_phase = 0; m_cnt = 0; m_req = 0;
    end else begin
      int period;
      bit tk;
      period = (m_ps == 0) ? 1 : (2 ** (m_ps + 1));
      tk = (m_en != 0) && (m_phase + 1 == period);
      if (bus_we && bus_addr == 4'h8) m_phase = 0;
      else if (m_en == 0 || tk)       m_phase = 0;
      else                            m_phase = m_phase + 1;
      if (bus_we && bus_addr == 4'h0) begin
        m_load = int'(bus_wdata & 32'hFFFF);
        m_cnt  = m_load;
      end else if (tk && m_cnt > 0) begin
        if (m_cnt == 1 && m_mode == 3) m_req = 1;
        m_cnt = m_cnt - 1;
      end
      if (bus_we && bus_addr == 4'h8) begin
        m_en   = int'(bus_wdata[7]);
        m_mode = int'(bus_wdata[5:4]);
        m_ps   = int'(bus_wdata[3:0]);
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [3:0] a);
    if (a == 4'h0) return 32'(m_load);
    if (a == 4'h8) return 32'((m_en << 7) | (m_mode << 4) | m_ps);
    return 32'd0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rst_req !== (m_req != 0)) begin
        errors++;
        $display("FAIL %s per-cycle rst_req actual=%0b expected=%0d", cur_tag, rst_req, m_req);
      end
      checks++;
      if (bus_rdata !== model_read(bus_addr)) begin
        errors++;
        $display("FAIL %s per-cycle rdata actual=%h expected=%h", cur_tag, bus_rdata, model_read(bus_addr));
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #2;
    bus_we = 1'b0; bus_addr = 4'h0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
    bus_addr = 4'h0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle(2);
    rst_n = 1'b1; idle(1);
  endtask

  initial begin
    #(1_500_000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(posedge clk); #2;
    do_reset();
    cur_tag = "R1";
    rd("R1 load reset", 4'h0, 32'h0);
    rd("R1 ctrl reset", 4'h8, 32'h0);
    chk("R1 rst_req reset", 32'(rst_req), 32'h0);

    cur_tag = "R2";
    wr(4'h0, 32'h1234_5678);
    rd("R2 load readback", 4'h0, 32'h0000_5678);
    cur_tag = "R3";
    wr(4'h8, 32'hFFFF_FFFF);
    rd("R3 ctrl readback", 4'h8, 32'h0000_00BF);
    rd("R3 other offset", 4'h4, 32'h0);
    wr(4'h8, 32'h0);
    do_reset();

    // R5/R6: immediate expiry and stickiness
    cur_tag = "R5";
    wr(4'h0, 32'd1);
    wr(4'h8, 32'hB0);
    chk("R5 not before step", 32'(rst_req), 32'h0);
    idle(1);
    chk("R5 expiry after one step", 32'(rst_req), 32'h1);
    cur_tag = "R6";
    wr(4'h8, 32'h0);
    wr(4'h0, 32'd100);
    idle(5);
    chk("R6 request sticky", 32'(rst_req), 32'h1);
    do_reset();
    chk("R6 cleared by reset", 32'(rst_req), 32'h0);

    // R4: prescale /4, load 3 -> expiry 12 edges after ctrl write
    cur_tag = "R4";
    wr(4'h0, 32'd3);
    wr(4'h8, 32'hB1);
    idle(11);
    chk("R4 code1 before 12", 32'(rst_req), 32'h0);
    idle(1);
    chk("R4 code1 at 12", 32'(rst_req), 32'h1);
    do_reset();
    // code 2 (/8), load 2 -> 16 edges
    wr(4'h0, 32'd2);
    wr(4'h8, 32'hB2);
    idle(15);
    chk("R4 code2 before 16", 32'(rst_req), 32'h0);
    idle(1);
    chk("R4 code2 at 16", 32'(rst_req), 32'h1);
    do_reset();
    // divider restart on control rewrite
    wr(4'h0, 32'd2);
    wr(4'h8, 32'hB1);
    idle(2);
    wr(4'h8, 32'hB1);
    idle(7);
    chk("R4 restart before full period", 32'(rst_req), 32'h0);
    idle(1);
    chk("R4 restart expiry", 32'(rst_req), 32'h1);
    do_reset();
    // code 15 (/65536), load 1
    wr(4'h0, 32'd1);
    wr(4'h8, 32'hBF);
    idle(65535);
    chk("R4 code15 before 65536", 32'(rst_req), 32'h0);
    idle(1);
    chk("R4 code15 at 65536", 32'(rst_req), 32'h1);
    do_reset();

    // R7: load of zero never expires
    cur_tag = "R7";
    wr(4'h0, 32'd0);
    wr(4'h8, 32'hB0);
    idle(20);
    chk("R7 zero load no expiry", 32'(rst_req), 32'h0);
    do_reset();

    // R8: disable holds the count, re-enable resumes
    cur_tag = "R8";
    wr(4'h0, 32'd2);
    wr(4'h8, 32'hB0);
    wr(4'h8, 32'h30);
    idle(20);
    chk("R8 disabled no expiry", 32'(rst_req), 32'h0);
    wr(4'h8, 32'hB0);
    chk("R8 held count not yet", 32'(rst_req), 32'h0);
    idle(1);
    chk("R8 resume from held 1", 32'(rst_req), 32'h1);
    do_reset();

    // R9: other modes count without request
    cur_tag = "R9";
    wr(4'h0, 32'd2);
    wr(4'h8, 32'h90);
    idle(10);
    chk("R9 mode1 no request", 32'(rst_req), 32'h0);
    wr(4'h8, 32'hB0);
    idle(5);
    chk("R9 counter reached zero", 32'(rst_req), 32'h0);
    do_reset();

    // R10: load beats a coincident step
    cur_tag = "R10";
    wr(4'h0, 32'd3);
    wr(4'h8, 32'hB0);
    idle(2);
    wr(4'h0, 32'd3);
    chk("R10 load wins over step", 32'(rst_req), 32'h0);
    idle(2);
    chk("R10 restarted count", 32'(rst_req), 32'h0);
    idle(1);
    chk("R10 expiry after reload", 32'(rst_req), 32'h1);
    do_reset();

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule